// File: doc/BRIEF.md
# Flash Array Program/Erase Engine

This block holds a byte-addressed memory array that behaves like NOR flash and carries out the write-side operations on it. The default geometry is a scaled-down copy of the full-size layout: pages of `2**PAGE_AW` bytes, sectors of `2**SECTOR_AW` bytes, blocks of `2**BLOCK_AW` bytes and a total of `2**ADDR_W` bytes. Setting the parameters to 8, 12, 15 and 17 gives 256-byte pages, 4-Kbyte sectors, 32-Kbyte blocks and 128 Kbytes in all. With those values there are 512 pages, 32 sectors and 4 blocks, and block k covers sectors 8k to 8k+7.

A request is one cycle wide. It names an operation, a byte address, a byte count for program and up to one page of data. The operation can be a page program, or an erase of a sector, a block or the whole chip. Program can only clear bits. Erase can only set whole aligned ranges back to FFh, and a single page cannot be erased. Each accepted operation walks the affected bytes one per cycle and keeps `busy` high for a parameterised number of cycles. These cycle counts stand in for the long program and erase times of a real array, which run from milliseconds up to seconds. A per-block protect mask can drop a request before it starts. Reads take one cycle and are refused while the engine is busy.

The controller is a three-state machine. `ST_IDLE` waits for a request. `ST_WALK` writes one byte per cycle. `ST_SETTLE` waits out the rest of the busy time. The transitions are:
- *accept*: `ST_IDLE`→`ST_WALK`, on a valid request that is not vetoed.
- *walk-done-expired*: `ST_WALK`→`ST_IDLE`, on the last byte when the timer is already at zero.
- *walk-done-pending*: `ST_WALK`→`ST_SETTLE`, on the last byte while the timer is still running.
- *expire*: `ST_SETTLE`→`ST_IDLE`, when the timer reaches zero.

Top module: `flash_pe_engine`

## Requirements
- R1: A sector erase (`cmd_op`=1) sets every byte of the `2**SECTOR_AW`-byte aligned sector containing `cmd_addr` to FFh. The address bits below the sector size are ignored, and bytes outside the sector keep their value.
- R2: A page program (`cmd_op`=0) writes `cmd_cnt_m1`+1 bytes into the page containing `cmd_addr`. Data byte i, taken from `cmd_data[8i+7:8i]`, goes to page offset (`cmd_addr` mod page size + i) mod page size. Offsets past the page end therefore wrap to the start of the same page.
- R3: Programming stores the old byte ANDed with the new byte, so a bit can only go from 1 to 0. Programming FFh leaves a byte unchanged.
- R4: A block erase (`cmd_op`=2) sets every byte of the `2**BLOCK_AW`-byte aligned block containing `cmd_addr` to FFh. Neighbouring blocks keep their value.
- R5: A chip erase (`cmd_op`=3) sets every byte of the array to FFh.
- R6: `busy` rises in the cycle after a request is accepted. It stays high for max(T_op, bytes touched) cycles and then clears. T_op is `T_PROG`, `T_SECT`, `T_BLK` or `T_CHIP`, matching the operation.
- R7: A request presented while `busy` is high is ignored. It does not change the array and does not lengthen the busy period.
- R8: Bit k of `prot_mask` protects block k. A program, sector erase or block erase whose target lies in a protected block is dropped. A chip erase is dropped when any mask bit is set. A dropped request leaves the array unchanged and does not raise `busy`. Requests to unprotected blocks still proceed.
- R9: A read with `rd_en` high while `busy` is low returns `rd_valid`=1 and the addressed byte on `rd_data` one cycle later.
- R10: A read with `rd_en` high while `busy` is high is refused. One cycle later `rd_valid`=0 and `rd_data`=0, and `rd_data` is 0 whenever `rd_valid` is 0.
- R11: After reset, `busy`, `rd_valid` and `rd_data` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Request strobe, one cycle |
| cmd_op | input | 2 | 0 program, 1 sector erase, 2 block erase, 3 chip erase |
| cmd_addr | input | ADDR_W | Target byte address |
| cmd_cnt_m1 | input | PAGE_AW | Program byte count minus one |
| cmd_data | input | 8·2**PAGE_AW | Program data, byte i in bits 8i+7:8i |
| prot_mask | input | 2**(ADDR_W-BLOCK_AW) | Per-block protect veto |
| busy | output | 1 | Operation in progress |
| rd_en | input | 1 | Read request |
| rd_addr | input | ADDR_W | Read byte address |
| rd_valid | output | 1 | Read data valid, one cycle after `rd_en` |
| rd_data | output | 8 | Read byte, 0 when not valid |

## Verification
The bench keeps the default geometry: 4-byte pages, 64-byte sectors, 512-byte blocks and 2048 bytes in all. At this size every byte can be read back after a chip erase, and page wrap can be reached with small counts. The busy counts are set to `T_PROG`=10, `T_SECT`=40, `T_BLK`=520 and `T_CHIP`=2100. With `T_SECT` below the 64-byte sector, the busy period of a sector erase is set by the walk length rather than the timer. The other three operations are set by the timer. Four blocks are enough to veto one block while its neighbours still run.

// File: rtl/flash_pe_pkg.sv
package flash_pe_pkg;

    typedef enum logic [1:0] {
        OP_PAGE_PROG  = 2'd0,
        OP_SECT_ERASE = 2'd1,
        OP_BLK_ERASE  = 2'd2,
        OP_CHIP_ERASE = 2'd3
    } fe_op_e;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_WALK   = 2'd1,
        ST_SETTLE = 2'd2
    } fe_state_e;

    function automatic int fe_max4(int a, int b, int c, int d);
        int m;
        m = a;
        if (b > m) m = b;
        if (c > m) m = c;
        if (d > m) m = d;
        return m;
    endfunction

    function automatic int fe_min4(int a, int b, int c, int d);
        int m;
        m = a;
        if (b < m) m = b;
        if (c < m) m = c;
        if (d < m) m = d;
        return m;
    endfunction

endpackage

// File: rtl/flash_pe_span.sv
// Decodes a request into aligned base, byte span, busy-timer load and veto.
module flash_pe_span
    import flash_pe_pkg::*;
#(
    parameter int ADDR_W    = 11,
    parameter int PAGE_AW   = 2,
    parameter int SECTOR_AW = 6,
    parameter int BLOCK_AW  = 9,
    parameter int T_PROG    = 12,
    parameter int T_SECT    = 80,
    parameter int T_BLK     = 600,
    parameter int T_CHIP    = 2100,
    parameter int TW        = 12,
    parameter int SPAN_W    = 12,
    parameter int NBLK      = 1 << (ADDR_W - BLOCK_AW)
) (
    input  fe_op_e              op,
    input  logic [ADDR_W-1:0]   addr,
    input  logic [PAGE_AW-1:0]  cnt_m1,
    input  logic [NBLK-1:0]     prot_mask,
    output logic [ADDR_W-1:0]   base,
    output logic [SPAN_W-1:0]   span,
    output logic [TW-1:0]       t_load,
    output logic                veto
);

    localparam int BIDX_W = (ADDR_W - BLOCK_AW) > 0 ? (ADDR_W - BLOCK_AW) : 1;
    localparam logic [ADDR_W-1:0] PAGE_KEEP   = ~ADDR_W'((1 << PAGE_AW) - 1);
    localparam logic [ADDR_W-1:0] SECTOR_KEEP = ~ADDR_W'((1 << SECTOR_AW) - 1);
    localparam logic [ADDR_W-1:0] BLOCK_KEEP  = ~ADDR_W'((1 << BLOCK_AW) - 1);

    logic [BIDX_W-1:0] blk_idx;
    logic [NBLK-1:0]   blk_hit;

    assign blk_idx = BIDX_W'(addr >> BLOCK_AW);

    // one comparator per block: is the target block protected
    for (genvar b = 0; b < NBLK; b++) begin : g_blk
        assign blk_hit[b] = (blk_idx == BIDX_W'(b)) && prot_mask[b];
    end

    always_comb begin
        base   = '0;
        span   = '0;
        t_load = '0;
        veto   = 1'b0;
        unique case (op)
            OP_PAGE_PROG: begin
                base   = addr & PAGE_KEEP;
                span   = SPAN_W'(cnt_m1) + SPAN_W'(1);
                t_load = TW'(T_PROG - 1);
                veto   = |blk_hit;
            end
            OP_SECT_ERASE: begin
                base   = addr & SECTOR_KEEP;
                span   = SPAN_W'(1 << SECTOR_AW);
                t_load = TW'(T_SECT - 1);
                veto   = |blk_hit;
            end
            OP_BLK_ERASE: begin
                base   = addr & BLOCK_KEEP;
                span   = SPAN_W'(1 << BLOCK_AW);
                t_load = TW'(T_BLK - 1);
                veto   = |blk_hit;
            end
            OP_CHIP_ERASE: begin
                base   = '0;
                span   = SPAN_W'(1 << ADDR_W);
                t_load = TW'(T_CHIP - 1);
                veto   = |prot_mask;
            end
            default: begin
                veto = 1'b1;
            end
        endcase
    end

endmodule

// File: rtl/flash_pe_timer.sv
// Down-counter that models the busy duration of an operation.
module flash_pe_timer #(
    parameter int TW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [TW-1:0] load_val,
    output logic          expired
);

    logic [TW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - TW'(1);
        end
    end

    assign expired = (cnt_q == '0);

endmodule

// File: rtl/flash_pe_array.sv
// Byte array with flash write semantics and a registered read port.
module flash_pe_array #(
    parameter int ADDR_W = 11,
    parameter int DEPTH  = 1 << ADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              wr_and,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_byte,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [7:0]        rd_byte
);

    logic [7:0] mem [DEPTH];

    // program clears bits only; erase writes the byte as given
    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[wr_addr] <= wr_and ? (mem[wr_addr] & wr_byte) : wr_byte;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_byte <= 8'h00;
        end else begin
            rd_byte <= rd_en ? mem[rd_addr] : 8'h00;
        end
    end

endmodule

// File: rtl/flash_pe_engine.sv
module flash_pe_engine
    import flash_pe_pkg::*;
#(
    parameter int ADDR_W    = 11,
    parameter int PAGE_AW   = 2,
    parameter int SECTOR_AW = 6,
    parameter int BLOCK_AW  = 9,
    parameter int T_PROG    = 12,
    parameter int T_SECT    = 80,
    parameter int T_BLK     = 600,
    parameter int T_CHIP    = 2100
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic                                  cmd_valid,
    input  logic [1:0]                            cmd_op,
    input  logic [ADDR_W-1:0]                     cmd_addr,
    input  logic [PAGE_AW-1:0]                    cmd_cnt_m1,
    input  logic [(8 << PAGE_AW)-1:0]             cmd_data,
    input  logic [(1 << (ADDR_W - BLOCK_AW))-1:0] prot_mask,
    output logic                                  busy,
    input  logic                                  rd_en,
    input  logic [ADDR_W-1:0]                     rd_addr,
    output logic                                  rd_valid,
    output logic [7:0]                            rd_data
);

    localparam int PAGE_BYTES = 1 << PAGE_AW;
    localparam int DATA_W     = 8 * PAGE_BYTES;
    localparam int NBLK       = 1 << (ADDR_W - BLOCK_AW);
    localparam int SPAN_W     = ADDR_W + 1;
    localparam int T_MAX      = fe_max4(T_PROG, T_SECT, T_BLK, T_CHIP);
    localparam int TW         = $clog2(T_MAX + 1);

    fe_state_e             state_q, state_d;
    logic [ADDR_W-1:0]     base_c, base_q;
    logic [SPAN_W-1:0]     span_c, span_q;
    logic [SPAN_W-1:0]     idx_q;
    logic [PAGE_AW-1:0]    off_q;
    logic [DATA_W-1:0]     data_q;
    logic                  prog_q;
    logic [TW-1:0]         t_load;
    logic                  veto;
    logic                  accept;
    logic                  t_expired;
    logic                  walk_last;
    logic                  wr_en;
    logic [ADDR_W-1:0]     wr_addr;
    logic [7:0]            wr_byte;
    logic [PAGE_AW-1:0]    lane;
    logic                  rd_go;

    flash_pe_span #(
        .ADDR_W    (ADDR_W),
        .PAGE_AW   (PAGE_AW),
        .SECTOR_AW (SECTOR_AW),
        .BLOCK_AW  (BLOCK_AW),
        .T_PROG    (T_PROG),
        .T_SECT    (T_SECT),
        .T_BLK     (T_BLK),
        .T_CHIP    (T_CHIP),
        .TW        (TW),
        .SPAN_W    (SPAN_W),
        .NBLK      (NBLK)
    ) u_span (
        .op        (fe_op_e'(cmd_op)),
        .addr      (cmd_addr),
        .cnt_m1    (cmd_cnt_m1),
        .prot_mask (prot_mask),
        .base      (base_c),
        .span      (span_c),
        .t_load    (t_load),
        .veto      (veto)
    );

    assign accept = cmd_valid && !veto && (state_q == ST_IDLE);

    flash_pe_timer #(.TW(TW)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (accept),
        .load_val (t_load),
        .expired  (t_expired)
    );

    assign walk_last = (idx_q == span_q - SPAN_W'(1));

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (accept) state_d = ST_WALK;
            ST_WALK:   if (walk_last) state_d = t_expired ? ST_IDLE : ST_SETTLE;
            ST_SETTLE: if (t_expired) state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // operation registers captured on accept, walk index advanced in ST_WALK
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q <= '0;
            span_q <= '0;
            idx_q  <= '0;
            off_q  <= '0;
            prog_q <= 1'b0;
            data_q <= '0;
        end else if (accept) begin
            base_q <= base_c;
            span_q <= span_c;
            idx_q  <= '0;
            off_q  <= cmd_addr[PAGE_AW-1:0];
            prog_q <= (fe_op_e'(cmd_op) == OP_PAGE_PROG);
            data_q <= cmd_data;
        end else if (state_q == ST_WALK) begin
            idx_q <= idx_q + SPAN_W'(1);
        end
    end

    // outputs of the machine
    always_comb begin
        busy    = (state_q != ST_IDLE);
        wr_en   = (state_q == ST_WALK);
        lane    = off_q + idx_q[PAGE_AW-1:0];
        if (prog_q) begin
            wr_addr = {base_q[ADDR_W-1:PAGE_AW], lane};
            wr_byte = data_q[8*int'(idx_q[PAGE_AW-1:0]) +: 8];
        end else begin
            wr_addr = base_q + idx_q[ADDR_W-1:0];
            wr_byte = 8'hFF;
        end
    end

    assign rd_go = rd_en && !busy;

    flash_pe_array #(.ADDR_W(ADDR_W)) u_array (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_and  (prog_q),
        .wr_addr (wr_addr),
        .wr_byte (wr_byte),
        .rd_en   (rd_go),
        .rd_addr (rd_addr),
        .rd_byte (rd_data)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid <= 1'b0;
        end else begin
            rd_valid <= rd_go;
        end
    end

endmodule

// File: rtl/flash_pe_engine_chk.sv
module flash_pe_engine_chk
    import flash_pe_pkg::*;
#(
    parameter int NBLK   = 4,
    parameter int T_PROG = 12,
    parameter int T_SECT = 80,
    parameter int T_BLK  = 600,
    parameter int T_CHIP = 2100
) (
    input logic            clk,
    input logic            rst_n,
    input logic            cmd_valid,
    input logic [1:0]      cmd_op,
    input logic [NBLK-1:0] prot_mask,
    input logic            busy,
    input logic            rd_en,
    input logic            rd_valid,
    input logic [7:0]      rd_data
);

    localparam int MIN_T = fe_min4(T_PROG, T_SECT, T_BLK, T_CHIP);

    int run_len;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_len <= 0;
        end else if (busy) begin
            run_len <= run_len + 1;
        end else begin
            run_len <= 0;
        end
    end

    // R6
    busy_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(cmd_valid));

    // R6
    busy_min_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> run_len >= MIN_T);

    // R8
    chip_veto_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !busy && cmd_op == 2'd3 && (|prot_mask)) |=> !busy);

    // R9
    rd_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !busy) |=> rd_valid);

    // R10
    rd_refuse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && busy) |=> (!rd_valid && rd_data == 8'h00));

    // R10
    rd_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_valid |-> rd_data == 8'h00);

endmodule

bind flash_pe_engine flash_pe_engine_chk #(
    .NBLK   (1 << (ADDR_W - BLOCK_AW)),
    .T_PROG (T_PROG),
    .T_SECT (T_SECT),
    .T_BLK  (T_BLK),
    .T_CHIP (T_CHIP)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_valid (cmd_valid),
    .cmd_op    (cmd_op),
    .prot_mask (prot_mask),
    .busy      (busy),
    .rd_en     (rd_en),
    .rd_valid  (rd_valid),
    .rd_data   (rd_data)
);

// File: tb/flash_pe_engine_bench.sv
module flash_pe_engine_bench;

    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W     = 11;
    localparam int PAGE_AW    = 2;
    localparam int SECTOR_AW  = 6;
    localparam int BLOCK_AW   = 9;
    localparam int T_PROG     = 10;
    localparam int T_SECT     = 40;
    localparam int T_BLK      = 520;
    localparam int T_CHIP     = 2100;
    localparam int PB         = 1 << PAGE_AW;
    localparam int DEPTH      = 1 << ADDR_W;
    localparam int NBLK       = 1 << (ADDR_W - BLOCK_AW);

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic                 cmd_valid = 1'b0;
    logic [1:0]           cmd_op = '0;
    logic [ADDR_W-1:0]    cmd_addr = '0;
    logic [PAGE_AW-1:0]   cmd_cnt_m1 = '0;
    logic [PB*8-1:0]      cmd_data = '0;
    logic [NBLK-1:0]      prot_mask = '0;
    logic                 busy;
    logic                 rd_en = 1'b0;
    logic [ADDR_W-1:0]    rd_addr = '0;
    logic                 rd_valid;
    logic [7:0]           rd_data;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    logic [7:0] ref_mem [DEPTH];

    typedef struct {
        bit         ok;
        logic [7:0] data;
        string      req;
        int         addr;
    } rd_item_t;

    rd_item_t exp_q[$];

    flash_pe_engine #(
        .ADDR_W(ADDR_W), .PAGE_AW(PAGE_AW), .SECTOR_AW(SECTOR_AW), .BLOCK_AW(BLOCK_AW),
        .T_PROG(T_PROG), .T_SECT(T_SECT), .T_BLK(T_BLK), .T_CHIP(T_CHIP)
    ) u_flash_pe_engine (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_addr(cmd_addr), .cmd_cnt_m1(cmd_cnt_m1), .cmd_data(cmd_data),
        .prot_mask(prot_mask), .busy(busy), .rd_en(rd_en), .rd_addr(rd_addr),
        .rd_valid(rd_valid), .rd_data(rd_data)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic chk(bit good, string req, string what, longint act, longint expv);
        n_chk++;
        if (!good) begin
            n_bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
        end
    endtask

    // reference model, written from the requirements
    task automatic model_prog(int a, int cnt_m1, logic [PB*8-1:0] d);
        for (int i = 0; i <= cnt_m1; i++) begin
            int t;
            t = (a / PB) * PB + ((a % PB) + i) % PB;
            ref_mem[t] = ref_mem[t] & d[8*i +: 8];
        end
    endtask

    task automatic model_fill(int lo, int n);
        for (int i = 0; i < n; i++) ref_mem[lo + i] = 8'hFF;
    endtask

    // all driver tasks start and end at a falling edge
    task automatic drive_cmd(int op, int a, int cnt_m1, logic [PB*8-1:0] d);
        cmd_valid  = 1'b1;
        cmd_op     = 2'(op);
        cmd_addr   = ADDR_W'(a);
        cmd_cnt_m1 = PAGE_AW'(cnt_m1);
        cmd_data   = d;
        @(negedge clk);
        cmd_valid  = 1'b0;
    endtask

    task automatic wait_idle(output int n);
        n = 0;
        while (busy && n < 5000) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic run_cmd(int op, int a, int cnt_m1, logic [PB*8-1:0] d, int exp_len, string req);
        int n;
        drive_cmd(op, a, cnt_m1, d);
        wait_idle(n);
        chk(n == exp_len, req, "busy cycles", n, exp_len);
    endtask

    task automatic rd(int a, bit ok, string req);
        rd_item_t it;
        it.ok   = ok;
        it.data = ok ? ref_mem[a] : 8'h00;
        it.req  = req;
        it.addr = a;
        exp_q.push_back(it);
        rd_en   = 1'b1;
        rd_addr = ADDR_W'(a);
        @(negedge clk);
        rd_en   = 1'b0;
    endtask

    task automatic check_range(int lo, int n, string req);
        for (int i = 0; i < n; i++) rd(lo + i, 1'b1, req);
    endtask

    // scoreboard monitor: compares each read result as it appears
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (rd_en) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R9", "unexpected read", 0, 0);
                end else begin
                    rd_item_t it;
                    it = exp_q.pop_front();
                    chk(rd_valid == it.ok, it.req, $sformatf("rd_valid @%0h", it.addr), rd_valid, it.ok);
                    chk(rd_data == it.data, it.req, $sformatf("rd_data @%0h", it.addr), rd_data, it.data);
                end
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            n_bad++;
            n_chk++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        int n;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11 reset state
        chk(busy == 1'b0, "R11", "busy", busy, 0);
        chk(rd_valid == 1'b0, "R11", "rd_valid", rd_valid, 0);
        chk(rd_data == 8'h00, "R11", "rd_data", rd_data, 0);

        // R5 chip erase, timer-bound busy
        run_cmd(3, 0, 0, '0, T_CHIP, "R6");
        model_fill(0, DEPTH);
        check_range(0, DEPTH, "R5");

        // R2 partial program
        run_cmd(0, 'h005, 2, 32'h78563412, T_PROG, "R6");
        model_prog('h005, 2, 32'h78563412);
        check_range('h004, 4, "R2");

        // R2 wrap + R3 AND
        run_cmd(0, 'h007, 2, 32'h00AA0FF0, T_PROG, "R2");
        model_prog('h007, 2, 32'h00AA0FF0);
        check_range('h004, 4, "R3");

        // R3 all-ones program leaves data alone
        run_cmd(0, 'h004, 3, 32'hFFFFFFFF, T_PROG, "R3");
        check_range('h004, 4, "R3");

        // R2 full page
        run_cmd(0, 'h008, 3, 32'h44332211, T_PROG, "R2");
        model_prog('h008, 3, 32'h44332211);
        check_range('h008, 4, "R2");

        // R1 sector erase with unaligned address, walk-bound busy
        for (int p = 0; p < 4; p++) begin
            int a;
            a = (p == 0) ? 'h03C : (p == 1) ? 'h040 : (p == 2) ? 'h07C : 'h080;
            run_cmd(0, a, 3, '0, T_PROG, "R2");
            model_prog(a, 3, '0);
        end
        run_cmd(1, 'h047, 0, '0, 64, "R6");
        model_fill('h040, 64);
        check_range('h03C, 8, "R1");
        check_range('h07C, 8, "R1");

        // R4 block erase
        for (int p = 0; p < 4; p++) begin
            int a;
            a = (p == 0) ? 'h1FC : (p == 1) ? 'h200 : (p == 2) ? 'h3FC : 'h400;
            run_cmd(0, a, 3, 32'h5A5A5A5A, T_PROG, "R2");
            model_prog(a, 3, 32'h5A5A5A5A);
        end
        run_cmd(2, 'h2A5, 0, '0, T_BLK, "R4");
        model_fill('h200, 512);
        check_range('h1FC, 8, "R4");
        check_range('h3FC, 8, "R4");

        // R8 protect veto on block 2
        prot_mask = 4'b0100;
        run_cmd(0, 'h401, 3, '0, 0, "R8");
        check_range('h400, 4, "R8");
        run_cmd(1, 'h410, 0, '0, 0, "R8");
        run_cmd(2, 'h5FF, 0, '0, 0, "R8");
        check_range('h400, 4, "R8");
        run_cmd(3, 0, 0, '0, 0, "R8");
        check_range('h004, 4, "R8");
        run_cmd(0, 'h00C, 3, 32'h0F0F0F0F, T_PROG, "R8");
        model_prog('h00C, 3, 32'h0F0F0F0F);
        check_range('h00C, 4, "R8");
        prot_mask = '0;

        // R7 / R10 activity during a block erase
        drive_cmd(2, 'h600, 0, '0);
        rd('h005, 1'b0, "R10");
        drive_cmd(0, 'h000, 3, '0);
        wait_idle(n);
        chk(n + 2 == T_BLK, "R7", "busy cycles with ignored request", n + 2, T_BLK);
        model_fill('h600, 512);
        check_range('h000, 4, "R7");
        check_range('h600, 4, "R4");
        check_range('h008, 4, "R9");

        repeat (4) @(negedge clk);
        chk(exp_q.size() == 0, "R9", "pending reads", exp_q.size(), 0);
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule